// File: doc/BRIEF.md
# SDRAM Command Timing Gate

This block sits between an SDRAM command sequencer and the memory command bus. The sequencer presents one command request per clock with a bank tag. The gate holds the request until every programmed minimum spacing from earlier commands has elapsed. While it holds a request it drives a no-operation on the bus. When it grants a request, the command appears on the bus the cycle after the granting edge. A down-counter per constraint reloads on the edge where the constraint starts.

A small configuration port programs four things: a row-cycle field (`cfg_row_cyc`), three one-bit long/short selects for activate-to-access, precharge and write recovery, and a read-capture shift option. The spacings that come from the row-cycle field are the field plus one clock. Activate-to-precharge has a floor of two clocks and activate-to-activate a floor of three. A configuration write is taken only when every timer and the read-capture pipeline are idle, so an interval that is already running is never cut short. Reads use a CAS latency of two. Each read's data word is captured on the rising edge, or half a clock later on the falling edge when the shift option is set.

Top module: `sdram_cmd_gate`

## Requirements
- R1: After reset the bus shows NOP (code 0), `rd_valid` is 0 and every timer is idle, so an activate is ready at once. The configuration resets to row-cycle 6 (binary 110), all three long bits set and capture shift off.
- R2: Between two commands drawn from {activate (1), auto-refresh (5)} there are at least row-cycle+1 clocks; refresh to refresh is exactly that when nothing else blocks.
- R3: Between two activates, to any banks, there are at least max(row-cycle+1, 3) clocks.
- R4: A precharge (4) to bank b is held until max(row-cycle+1, 2) clocks after the last activate to bank b; activates to other banks do not hold it.
- R5: A read (2) or write (3) to bank b is held until 1 clock (activate-to-access bit 0) or 2 clocks (bit 1) after the last activate to bank b.
- R6: After a precharge to any bank, an activate or auto-refresh is held for 1 clock (precharge bit 0) or 2 clocks (bit 1).
- R7: A precharge to bank b is held until 1 clock (write-recovery bit 0) or 2 clocks (bit 1) after the last write to bank b.
- R8: A mode register set (6) occupies one clock: an activate may follow on the very next edge. A mode register set itself waits for the row-cycle and precharge spacings.
- R9: `req_ready` reflects the request this cycle whatever `req_valid` is. A request is granted on an edge where both are 1. The command code and bank appear on `cmd_out`/`cmd_bank` for the one cycle after that edge; otherwise `cmd_out` is NOP. The codes are NOP 0, ACT 1, RD 2, WR 3, PRE 4, REF 5, MRS 6, and code 7 is treated as NOP.
- R10: A configuration write with `cfg_we` takes effect on an edge only if no timer is running, the read pipeline is empty and no command is granted on that edge. Otherwise it is dropped.
- R11: For a read granted at edge E with shift off, `rd_valid` is 1 for one cycle after edge E+3 and `rd_data` holds `dq_in` sampled at rising edge E+3. With shift on, `rd_valid` is 1 after edge E+4 and `rd_data` holds `dq_in` sampled at the falling edge that follows E+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write request |
| cfg_row_cyc | input | 3 | Row-cycle field (intervals = field+1) |
| cfg_rcd_long | input | 1 | Activate-to-access 2 clocks when 1 |
| cfg_rp_long | input | 1 | Precharge spacing 2 clocks when 1 |
| cfg_wr_long | input | 1 | Write recovery 2 clocks when 1 |
| cfg_rd_shift | input | 1 | Capture read data half a clock later |
| req_valid | input | 1 | Command request present |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | BANK_W | Requested bank |
| req_ready | output | 1 | Request may issue at the next edge |
| cmd_out | output | 3 | Command on the memory bus |
| cmd_bank | output | BANK_W | Bank on the memory bus |
| dq_in | input | DW | Read data from memory |
| rd_valid | output | 1 | Captured read word valid |
| rd_data | output | DW | Captured read word |

## Verification
Two functions can fall on the same edge: a configuration write and a command grant, or a configuration write and a timer or read capture still in progress. The bench provokes both on purpose. It writes a short row-cycle setting on the cycle right after an activate, and again on the same edge as a granted refresh. It then measures the next activate-to-activate gap, which must still show the old seven-clock spacing. Random traffic with sparse configuration writes repeats these collisions, and a bench model of timer deadlines judges each write as taken or dropped.

// File: rtl/sdram_gate_pkg.sv
package sdram_gate_pkg;
  localparam int RC_W    = 3;
  localparam int RAS_MIN = 2;
  localparam int RRD_MIN = 3;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } sdcmd_e;

  typedef struct packed {
    logic [RC_W-1:0] row_cyc;
    logic            rcd_long;
    logic            rp_long;
    logic            wr_long;
    logic            rd_shift;
  } gate_cfg_t;
endpackage

// File: rtl/sdram_gate_dctr.sv
module sdram_gate_dctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] q;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = load | (q != '0);
    q_d  = load ? load_val : (q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  assign zero = (q == '0);

  // an expired timer stays expired until reloaded
  assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/sdram_gate_bank.sv
module sdram_gate_bank #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act_ld,
  input  logic         wr_ld,
  input  logic [W-1:0] ras_val,
  input  logic [W-1:0] rcd_val,
  input  logic [W-1:0] wrr_val,
  output logic         ras_ok,
  output logic         rcd_ok,
  output logic         wrr_ok
);
  sdram_gate_dctr #(.W(W)) u_ras (
    .clk(clk), .rst_n(rst_n), .load(act_ld), .load_val(ras_val), .zero(ras_ok));
  sdram_gate_dctr #(.W(W)) u_rcd (
    .clk(clk), .rst_n(rst_n), .load(act_ld), .load_val(rcd_val), .zero(rcd_ok));
  sdram_gate_dctr #(.W(W)) u_wrr (
    .clk(clk), .rst_n(rst_n), .load(wr_ld), .load_val(wrr_val), .zero(wrr_ok));
endmodule

// File: rtl/sdram_gate_cfg.sv
module sdram_gate_cfg
  import sdram_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_req,
  input  gate_cfg_t wr_data,
  input  logic      quiet,
  output gate_cfg_t cfg_q
);
  logic apply;

  always_comb apply = wr_req & quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.row_cyc  <= {RC_W{1'b1}} - 1'b1;
      cfg_q.rcd_long <= 1'b1;
      cfg_q.rp_long  <= 1'b1;
      cfg_q.wr_long  <= 1'b1;
      cfg_q.rd_shift <= 1'b0;
    end else if (apply) begin
      cfg_q <= wr_data;
    end
  end

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet |=> $stable(cfg_q));
endmodule

// File: rtl/sdram_gate_rdcap.sv
module sdram_gate_rdcap #(
  parameter int DW = 16,
  parameter int CL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_issue,
  input  logic          shift,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam int PL = CL + 2;

  logic [PL-1:0] pipe_q;
  logic [PL-1:0] pipe_d;
  logic [DW-1:0] neg_q;
  logic [DW-1:0] data_d;
  logic          vld_d;

  always_comb begin
    pipe_d = {pipe_q[PL-2:0], rd_issue};
    vld_d  = shift ? pipe_q[PL-1] : pipe_q[PL-2];
    data_d = shift ? neg_q : dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe_q   <= pipe_d;
      rd_valid <= vld_d;
      if (vld_d) rd_data <= data_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= '0;
    else        neg_q <= dq_in;
  end

  assign busy = |pipe_q;
endmodule

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate
  import sdram_gate_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int DW       = 16,
  parameter int CAS_LAT  = 2,
  parameter int MRS_CLKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_row_cyc,
  input  logic              cfg_rcd_long,
  input  logic              cfg_rp_long,
  input  logic              cfg_wr_long,
  input  logic              cfg_rd_shift,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  output logic              req_ready,
  output logic [2:0]        cmd_out,
  output logic [BANK_W-1:0] cmd_bank,
  input  logic [DW-1:0]     dq_in,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  localparam int NB = 1 << BANK_W;
  localparam int CW = RC_W;
  localparam int SW = CW + 2;

  gate_cfg_t cfg_q;
  gate_cfg_t cfg_wdata;
  logic [CW-1:0] rc_val, ras_val, rrd_val, rcd_val, rp_val, wrr_val, mrs_val;
  logic rc_ok, rrd_ok, rp_ok, mrs_ok, rd_busy;
  logic [NB-1:0] ras_ok, rcd_ok, wrr_ok, act_b, wr_b;
  logic grant, is_act, is_rd, is_wr, is_pre, is_ref, is_mrs, idle, quiet;
  logic [2:0] cmd_d;
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    cfg_wdata.row_cyc  = cfg_row_cyc;
    cfg_wdata.rcd_long = cfg_rcd_long;
    cfg_wdata.rp_long  = cfg_rp_long;
    cfg_wdata.wr_long  = cfg_wr_long;
    cfg_wdata.rd_shift = cfg_rd_shift;
  end

  // reload values are the interval in clocks minus one
  always_comb begin
    rc_val  = cfg_q.row_cyc;
    ras_val = (cfg_q.row_cyc < CW'(RAS_MIN - 1)) ? CW'(RAS_MIN - 1) : cfg_q.row_cyc;
    rrd_val = (cfg_q.row_cyc < CW'(RRD_MIN - 1)) ? CW'(RRD_MIN - 1) : cfg_q.row_cyc;
    rcd_val = CW'(cfg_q.rcd_long);
    rp_val  = CW'(cfg_q.rp_long);
    wrr_val = CW'(cfg_q.wr_long);
    mrs_val = CW'(MRS_CLKS - 1);
  end

  always_comb begin
    case (sdcmd_e'(req_cmd))
      CMD_ACT:          req_ready = rc_ok & rrd_ok & rp_ok & mrs_ok;
      CMD_RD, CMD_WR:   req_ready = rcd_ok[req_bank] & mrs_ok;
      CMD_PRE:          req_ready = ras_ok[req_bank] & wrr_ok[req_bank] & mrs_ok;
      CMD_REF, CMD_MRS: req_ready = rc_ok & rp_ok & mrs_ok;
      default:          req_ready = 1'b1;
    endcase
    grant  = req_valid & req_ready;
    is_act = grant & (req_cmd == CMD_ACT);
    is_rd  = grant & (req_cmd == CMD_RD);
    is_wr  = grant & (req_cmd == CMD_WR);
    is_pre = grant & (req_cmd == CMD_PRE);
    is_ref = grant & (req_cmd == CMD_REF);
    is_mrs = grant & (req_cmd == CMD_MRS);
    idle   = rc_ok & rrd_ok & rp_ok & mrs_ok & (&ras_ok) & (&rcd_ok) & (&wrr_ok) & ~rd_busy;
    quiet  = idle & ~grant;
  end

  sdram_gate_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_req(cfg_we), .wr_data(cfg_wdata),
    .quiet(quiet), .cfg_q(cfg_q));

  sdram_gate_dctr #(.W(CW)) u_rc (
    .clk(clk), .rst_n(rst_n), .load(is_act | is_ref), .load_val(rc_val), .zero(rc_ok));
  sdram_gate_dctr #(.W(CW)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(is_act), .load_val(rrd_val), .zero(rrd_ok));
  sdram_gate_dctr #(.W(CW)) u_rp (
    .clk(clk), .rst_n(rst_n), .load(is_pre), .load_val(rp_val), .zero(rp_ok));
  sdram_gate_dctr #(.W(CW)) u_mrs (
    .clk(clk), .rst_n(rst_n), .load(is_mrs), .load_val(mrs_val), .zero(mrs_ok));

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign act_b[b] = is_act & (req_bank == BANK_W'(b));
    assign wr_b[b]  = is_wr  & (req_bank == BANK_W'(b));
    sdram_gate_bank #(.W(CW)) u_bank (
      .clk(clk), .rst_n(rst_n), .act_ld(act_b[b]), .wr_ld(wr_b[b]),
      .ras_val(ras_val), .rcd_val(rcd_val), .wrr_val(wrr_val),
      .ras_ok(ras_ok[b]), .rcd_ok(rcd_ok[b]), .wrr_ok(wrr_ok[b]));
  end

  sdram_gate_rdcap #(.DW(DW), .CL(CAS_LAT)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .rd_issue(is_rd), .shift(cfg_q.rd_shift),
    .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data), .busy(rd_busy));

  always_comb begin
    cmd_d  = (grant && (req_cmd != 3'd7)) ? req_cmd : CMD_NOP;
    bank_d = grant ? req_bank : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_out  <= CMD_NOP;
      cmd_bank <= '0;
    end else begin
      cmd_out  <= cmd_d;
      cmd_bank <= bank_d;
    end
  end

  // bus-side spacing monitors feeding the assertions below
  logic [SW-1:0] since_act, since_pre, act_need, pre_need;
  logic act_seen, pre_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '0; since_pre <= '0; act_need <= '0; pre_need <= '0;
      act_seen  <= 1'b0; pre_seen <= 1'b0;
    end else begin
      if (cmd_out == CMD_ACT) begin
        since_act <= SW'(1);
        act_need  <= SW'(rrd_val) + SW'(1);
        act_seen  <= 1'b1;
      end else if (since_act != '1) begin
        since_act <= since_act + 1'b1;
      end
      if (cmd_out == CMD_PRE) begin
        since_pre <= SW'(1);
        pre_need  <= SW'(rp_val) + SW'(1);
        pre_seen  <= 1'b1;
      end else if (since_pre != '1) begin
        since_pre <= since_pre + 1'b1;
      end
    end
  end

  assert_act_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == CMD_ACT && act_seen) |-> (since_act >= act_need));

  assert_pre_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_out == CMD_ACT || cmd_out == CMD_REF) && pre_seen) |-> (since_pre >= pre_need));

  assert_rd_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(cmd_out, CAS_LAT + 1) == CMD_RD || $past(cmd_out, CAS_LAT + 2) == CMD_RD));
endmodule

// File: tb/sdram_cmd_gate_bench.sv
`timescale 1ns/100ps
module sdram_cmd_gate_bench;
  localparam int BW = 2;
  localparam int NB = 4;
  localparam int DW = 16;
  localparam int CL = 2;

  logic clk, rst_n, cfg_we, cfg_rcd_long, cfg_rp_long, cfg_wr_long, cfg_rd_shift;
  logic [2:0] cfg_row_cyc, req_cmd, cmd_out;
  logic req_valid, req_ready, rd_valid;
  logic [BW-1:0] req_bank, cmd_bank;
  logic [DW-1:0] dq_in, rd_data;

  sdram_cmd_gate #(.BANK_W(BW), .DW(DW), .CAS_LAT(CL), .MRS_CLKS(1)) u_sdram_cmd_gate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row_cyc(cfg_row_cyc),
    .cfg_rcd_long(cfg_rcd_long), .cfg_rp_long(cfg_rp_long), .cfg_wr_long(cfg_wr_long),
    .cfg_rd_shift(cfg_rd_shift), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_ready(req_ready), .cmd_out(cmd_out), .cmd_bank(cmd_bank),
    .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int hval = 0;
  always @(posedge clk or negedge clk) begin
    #0.2;
    hval = hval + 1;
    dq_in = hval[DW-1:0];
  end

  int nchk = 0, nerr = 0;
  int m;
  int d_rc, d_rrd, d_rp, d_mrs, d_rd;
  int d_ras[NB], d_rcd[NB], d_wr[NB];
  int mrc; bit mrcd, mrp, mwr, msh;
  bit sv[16]; logic [DW-1:0] sd[16];

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic string tag_of(input int c);
    case (c)
      1: return "R3";
      2, 3: return "R5";
      4: return "R4";
      5: return "R2";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic bit m_ready(input int c, input int b);
    case (c)
      1: return m >= d_rc && m >= d_rrd && m >= d_rp && m >= d_mrs;
      2, 3: return m >= d_rcd[b] && m >= d_mrs;
      4: return m >= d_ras[b] && m >= d_wr[b] && m >= d_mrs;
      5, 6: return m >= d_rc && m >= d_rp && m >= d_mrs;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit m_idle();
    bit ok = (m >= d_rc) && (m >= d_rrd) && (m >= d_rp) && (m >= d_mrs) && (m >= d_rd);
    for (int i = 0; i < NB; i++)
      ok = ok && (m >= d_ras[i]) && (m >= d_rcd[i]) && (m >= d_wr[i]);
    return ok;
  endfunction

  task automatic cycle(input bit v, input int c, input int b, input bit we, output bit g);
    bit er, idl;
    req_valid = v; req_cmd = c[2:0]; req_bank = b[BW-1:0]; cfg_we = we;
    @(negedge clk);
    er = m_ready(c, b);
    chk(tag_of(c), req_ready, er);
    g = v && er;
    idl = m_idle();
    @(posedge clk); #1;
    if (we && idl && !g) begin
      mrc = cfg_row_cyc; mrcd = cfg_rcd_long; mrp = cfg_rp_long;
      mwr = cfg_wr_long; msh = cfg_rd_shift;
    end
    chk("R9", cmd_out, g ? c : 0);
    if (g) chk("R9", cmd_bank, b);
    chk("R11", rd_valid, sv[m % 16]);
    if (sv[m % 16]) chk("R11", rd_data, sd[m % 16]);
    sv[m % 16] = 1'b0;
    if (g) begin
      case (c)
        1: begin
          d_rc = m + mrc + 1; d_rrd = m + mx(mrc + 1, 3);
          d_ras[b] = m + mx(mrc + 1, 2); d_rcd[b] = m + (mrcd ? 2 : 1);
        end
        2: begin
          d_rd = m + CL + 3;
          if (msh) begin sv[(m + 4) % 16] = 1'b1; sd[(m + 4) % 16] = dq_in + 6; end
          else     begin sv[(m + 3) % 16] = 1'b1; sd[(m + 3) % 16] = dq_in + 5; end
        end
        3: d_wr[b] = m + (mwr ? 2 : 1);
        4: d_rp = m + (mrp ? 2 : 1);
        5: d_rc = m + mrc + 1;
        6: d_mrs = m + 1;
        default: ;
      endcase
    end
    m++;
  endtask

  task automatic idle_n(input int n);
    bit g;
    for (int i = 0; i < n; i++) cycle(1'b0, 0, 0, 1'b0, g);
  endtask

  task automatic cfgw(input int rc, input bit rcd, input bit rp, input bit wr, input bit sh);
    bit g;
    idle_n(12);
    cfg_row_cyc = rc[2:0]; cfg_rcd_long = rcd; cfg_rp_long = rp;
    cfg_wr_long = wr; cfg_rd_shift = sh;
    cycle(1'b0, 0, 0, 1'b1, g);
  endtask

  task automatic issue(input int c, input int b);
    bit g = 1'b0;
    while (!g) cycle(1'b1, c, b, 1'b0, g);
  endtask

  task automatic gap(input int c1, input int b1, input int c2, input int b2,
                     input int exp, input string tag);
    bit g = 1'b0;
    int n = 0;
    idle_n(12);
    issue(c1, b1);
    while (!g) begin cycle(1'b1, c2, b2, 1'b0, g); n++; end
    chk(tag, n, exp);
  endtask

  initial begin
    #(200000 * 4);
    nerr++; nchk++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    bit g;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_we = 0; req_valid = 0; req_cmd = 3'd1; req_bank = '0;
    cfg_row_cyc = 0; cfg_rcd_long = 0; cfg_rp_long = 0; cfg_wr_long = 0; cfg_rd_shift = 0;
    d_rc = 0; d_rrd = 0; d_rp = 0; d_mrs = 0; d_rd = 0;
    for (int i = 0; i < NB; i++) begin d_ras[i] = 0; d_rcd[i] = 0; d_wr[i] = 0; end
    for (int i = 0; i < 16; i++) sv[i] = 1'b0;
    mrc = 6; mrcd = 1; mrp = 1; mwr = 1; msh = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    m = 1;
    chk("R1", cmd_out, 0);
    chk("R1", rd_valid, 0);
    @(negedge clk); chk("R1", req_ready, 1);
    @(posedge clk); #1; m++;
    // reset configuration: row-cycle 6, long bits set
    gap(5, 0, 5, 0, 7, "R1");
    gap(3, 1, 4, 1, 2, "R1");

    cfgw(6, 1, 1, 1, 0);
    gap(5, 0, 5, 0, 7, "R2");
    gap(1, 0, 1, 1, 7, "R3");
    gap(1, 0, 4, 0, 7, "R4");
    gap(1, 0, 4, 1, 1, "R4");
    gap(1, 1, 2, 1, 2, "R5");
    gap(4, 2, 1, 2, 2, "R6");
    gap(4, 2, 5, 0, 2, "R6");
    gap(3, 1, 4, 1, 2, "R7");
    gap(6, 0, 1, 0, 1, "R8");

    // R10: write while a timer runs, then write on a granted edge
    idle_n(12);
    issue(1, 0);
    cfg_row_cyc = 0; cfg_rcd_long = 0; cfg_rp_long = 0; cfg_wr_long = 0;
    cycle(1'b0, 0, 0, 1'b1, g);
    gap(1, 0, 1, 1, 7, "R10");
    idle_n(12);
    cfg_row_cyc = 0;
    cycle(1'b1, 5, 0, 1'b1, g);
    chk("R10", g, 1);
    gap(1, 0, 1, 1, 7, "R10");

    cfgw(0, 0, 0, 0, 0);
    gap(5, 0, 5, 0, 1, "R2");
    gap(1, 0, 1, 1, 3, "R3");
    gap(1, 0, 4, 0, 2, "R4");
    gap(1, 2, 3, 2, 1, "R5");
    gap(4, 0, 1, 0, 1, "R6");
    gap(3, 3, 4, 3, 1, "R7");
    cfgw(3, 0, 0, 0, 0);
    gap(1, 0, 1, 1, 4, "R3");
    gap(1, 0, 4, 0, 4, "R4");
    cfgw(1, 0, 0, 0, 0);
    gap(1, 0, 4, 0, 2, "R4");
    gap(1, 0, 1, 1, 3, "R3");
    gap(5, 0, 5, 0, 2, "R2");

    // R11: capture timing with shift off then on, back-to-back reads
    cfgw(2, 1, 0, 0, 0);
    issue(1, 0); idle_n(4);
    issue(2, 0); issue(2, 0); issue(2, 0); idle_n(8);
    cfgw(2, 1, 0, 0, 1);
    issue(1, 1); idle_n(4);
    issue(2, 1); idle_n(2); issue(2, 1); issue(2, 1); idle_n(8);

    for (int i = 0; i < 3000; i++) begin
      int c = 1 + int'($urandom % 6);
      int b = int'($urandom % NB);
      bit v = ($urandom % 2) == 0;
      bit we = ($urandom % 24) == 0;
      cfg_row_cyc = 3'($urandom); cfg_rcd_long = 1'($urandom);
      cfg_rp_long = 1'($urandom); cfg_wr_long = 1'($urandom);
      cfg_rd_shift = 1'($urandom);
      cycle(v, c, b, we, g);
    end
    idle_n(10);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule